// File: doc/BRIEF.md
# DMA Channel Configuration Register Bank

This block keeps the per-channel control bits of an eight-channel DMA controller and presents them to the transfer engine as plain vectors. Each channel attribute (enable, burst-only, alternate structure, high priority, request masking) lives in one vector with two write addresses. Writing ones to the set address turns bits on, and writing ones to the clear address turns bits off. Bits written as zero are untouched, so software never has to read, modify and write back a vector. The set address reads back the live vector.

The bank also holds a global on/off bit, a sticky bus-error flag that any write to its address clears, a one-shot software request register that emits single-cycle pulses, and the control-table base pointer. The pointer only accepts 1 KiB aligned addresses in the upper memory region. An alternate-table pointer is derived from it and can only be read.

The register bus is a plain strobe interface with no back-pressure. A write (`bus_wr`) or a read (`bus_rd`) is accepted in every cycle it is high. Read data returns one cycle later with `rsp_valid`. That data reflects the state before any write in the same cycle. The engine-facing pins are plain levels and pulses.

Top module: `dmacfg_bank`

## Requirements
- R1: After reset every attribute vector, the on/off bit, the error flag, the request pulses and the base pointer are zero, and the alternate pointer reads 0x0000_0200.
- R2: A write to an attribute's set address (enable 8, burst 10, alternate 12, priority 14, mask 16) sets each channel bit whose data bit [7:0] is one and leaves the other bits unchanged.
- R3: A write to an attribute's clear address (its set address plus one) clears each channel bit whose data bit is one and leaves the other bits unchanged.
- R4: A read returns data one cycle after the strobe, with `rsp_valid` high. A set address returns its vector in bits [7:0], and a clear address returns zero.
- R5: The five attribute vectors are independent: a write to one pair never changes another vector.
- R6: A write to address 4 produces `sw_req` equal to the data bits [7:0] for exactly the next cycle, and then returns to zero. Address 4 reads as zero.
- R7: Bit 0 of address 0 is the global on/off bit, drives `master_on` and reads back. The other bits are ignored.
- R8: `err_event` sets `err_flag`, and address 1 bit 0 reads it back. Any write to address 1 clears the flag unless `err_event` is high in the same cycle, in which case the flag stays set.
- R9: A write to address 2 is taken only when data bits [9:0] are zero and the value is at least 0x2000_0000. Otherwise the previous pointer is kept.
- R10: Address 3 and `alt_base` always equal the base pointer plus 0x200, and writes to address 3 are ignored.
- R11: Writes to unused addresses change no state, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rsp_rdata | output | 32 | Read data |
| err_event | input | 1 | Bus error reported by the engine |
| err_flag | output | 1 | Sticky error flag |
| master_on | output | 1 | Global controller enable |
| chan_en | output | 8 | Channel enable vector |
| burst_only | output | 8 | Burst-only vector |
| alt_sel | output | 8 | Alternate structure select vector |
| hi_prio | output | 8 | High priority vector |
| req_mask | output | 8 | Request mask vector |
| sw_req | output | 8 | Software request pulses |
| table_base | output | 32 | Control table base pointer |
| alt_base | output | 32 | Alternate table base pointer |

## Verification
The one collision this block must settle is an error event from the engine in the same cycle as a software write that clears the error. The bench drives `err_event` and a write to address 1 on the same clock edge. It then judges the outcome at `err_flag` and through a read of address 1, which must both show the flag still set. It also checks that the clear alone works, and that an event alone sets the flag.

// File: rtl/dmacfg_pkg.sv
package dmacfg_pkg;
  localparam int NATTR = 5;
  // attribute index; pair i sits at set address PAIR_BASE + 2*i
  localparam int AT_ENA   = 0;
  localparam int AT_BURST = 1;
  localparam int AT_ALT   = 2;
  localparam int AT_PRIO  = 3;
  localparam int AT_MASK  = 4;

  localparam int ADR_CFG   = 0;
  localparam int ADR_ERR   = 1;
  localparam int ADR_BASE  = 2;
  localparam int ADR_ALT   = 3;
  localparam int ADR_SWREQ = 4;
  localparam int PAIR_BASE = 8;

  function automatic int set_adr(input int idx);
    return PAIR_BASE + 2 * idx;
  endfunction

  function automatic int clr_adr(input int idx);
    return PAIR_BASE + 2 * idx + 1;
  endfunction
endpackage

// File: rtl/dmacfg_attr_vec.sv
module dmacfg_attr_vec #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] mask,
  output logic [NCH-1:0] vec
);
  always_ff @(posedge clk) begin
    if (!rst_n)      vec <= '0;
    else if (set_we) vec <= vec | mask;
    else if (clr_we) vec <= vec & ~mask;
  end
endmodule

// File: rtl/dmacfg_base_reg.sv
module dmacfg_base_reg #(
  parameter int          DW      = 32,
  parameter int          ALIGN   = 10,
  parameter logic [31:0] MIN_ADR = 32'h2000_0000,
  parameter logic [31:0] ALT_OFS = 32'h0000_0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] base,
  output logic [DW-1:0] alt
);
  localparam logic [DW-1:0] MIN_W = DW'(MIN_ADR);
  localparam logic [DW-1:0] OFS_W = DW'(ALT_OFS);

  logic legal;
  assign legal = (wdata[ALIGN-1:0] == '0) && (wdata >= MIN_W);

  always_ff @(posedge clk) begin
    if (!rst_n)          base <= '0;
    else if (we && legal) base <= wdata;
  end

  assign alt = base + OFS_W;
endmodule

// File: rtl/dmacfg_sticky.sv
module dmacfg_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_in,
  input  logic clr_in,
  output logic flag
);
  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_in) flag <= 1'b1;
    else if (clr_in) flag <= 1'b0;
  end
endmodule

// File: rtl/dmacfg_bank.sv
module dmacfg_bank
  import dmacfg_pkg::*;
#(
  parameter int          NCH     = 8,
  parameter int          ADDR_W  = 5,
  parameter int          DW      = 32,
  parameter int          ALIGN   = 10,
  parameter logic [31:0] MIN_ADR = 32'h2000_0000,
  parameter logic [31:0] ALT_OFS = 32'h0000_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic              err_event,
  output logic              err_flag,
  output logic              master_on,
  output logic [NCH-1:0]    chan_en,
  output logic [NCH-1:0]    burst_only,
  output logic [NCH-1:0]    alt_sel,
  output logic [NCH-1:0]    hi_prio,
  output logic [NCH-1:0]    req_mask,
  output logic [NCH-1:0]    sw_req,
  output logic [DW-1:0]     table_base,
  output logic [DW-1:0]     alt_base
);
  logic [NATTR-1:0][NCH-1:0] attr_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  // attribute vectors, one per set/clear pair
  for (genvar g = 0; g < NATTR; g++) begin : g_attr
    logic set_we, clr_we;
    assign set_we = bus_wr && hit(bus_addr, set_adr(g));
    assign clr_we = bus_wr && hit(bus_addr, clr_adr(g));
    dmacfg_attr_vec #(.NCH(NCH)) u_vec (
      .clk   (clk),
      .rst_n (rst_n),
      .set_we(set_we),
      .clr_we(clr_we),
      .mask  (bus_wdata[NCH-1:0]),
      .vec   (attr_q[g])
    );
  end

  assign chan_en    = attr_q[AT_ENA];
  assign burst_only = attr_q[AT_BURST];
  assign alt_sel    = attr_q[AT_ALT];
  assign hi_prio    = attr_q[AT_PRIO];
  assign req_mask   = attr_q[AT_MASK];

  // base pointer and derived alternate pointer
  dmacfg_base_reg #(
    .DW(DW), .ALIGN(ALIGN), .MIN_ADR(MIN_ADR), .ALT_OFS(ALT_OFS)
  ) u_base (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (bus_wr && hit(bus_addr, ADR_BASE)),
    .wdata(bus_wdata),
    .base (table_base),
    .alt  (alt_base)
  );

  // sticky bus-error flag
  dmacfg_sticky u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set_in(err_event),
    .clr_in(bus_wr && hit(bus_addr, ADR_ERR)),
    .flag  (err_flag)
  );

  // global on/off and one-shot requests
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_on <= 1'b0;
      sw_req    <= '0;
    end else begin
      if (bus_wr && hit(bus_addr, ADR_CFG)) master_on <= bus_wdata[0];
      sw_req <= (bus_wr && hit(bus_addr, ADR_SWREQ)) ? bus_wdata[NCH-1:0] : '0;
    end
  end

  // read multiplexer
  logic [DW-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (hit(bus_addr, ADR_CFG))       rd_d[0] = master_on;
    else if (hit(bus_addr, ADR_ERR))  rd_d[0] = err_flag;
    else if (hit(bus_addr, ADR_BASE)) rd_d = table_base;
    else if (hit(bus_addr, ADR_ALT))  rd_d = alt_base;
    for (int i = 0; i < NATTR; i++) begin
      if (hit(bus_addr, set_adr(i))) rd_d[NCH-1:0] = attr_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_rd;
      if (bus_rd) rsp_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/dmacfg_bank_chk.sv
module dmacfg_bank_chk
  import dmacfg_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  parameter int ALIGN  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              rsp_valid,
  input logic              err_event,
  input logic              err_flag,
  input logic [NCH-1:0]    chan_en,
  input logic [NCH-1:0]    burst_only,
  input logic [NCH-1:0]    req_mask,
  input logic [NCH-1:0]    sw_req,
  input logic [DW-1:0]     table_base
);
  // R2
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(set_adr(AT_ENA))) |=>
      ((chan_en & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  // R3
  ena_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(clr_adr(AT_ENA))) |=>
      ((chan_en & $past(bus_wdata[NCH-1:0])) == '0));

  // R5
  pair_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(set_adr(AT_ENA))) |=>
      ($stable(burst_only) && $stable(req_mask)));

  // R6
  swreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(ADR_SWREQ)) |=>
      (sw_req == $past(bus_wdata[NCH-1:0])));

  // R6
  swreq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(ADR_SWREQ)) |=> (sw_req == '0));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> err_flag);

  // R9
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    table_base[ALIGN-1:0] == '0);

  // R4
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rsp_valid);
endmodule

bind dmacfg_bank dmacfg_bank_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .DW(DW), .ALIGN(ALIGN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rsp_valid (rsp_valid),
  .err_event (err_event),
  .err_flag  (err_flag),
  .chan_en   (chan_en),
  .burst_only(burst_only),
  .req_mask  (req_mask),
  .sw_req    (sw_req),
  .table_base(table_base)
);

// File: tb/dmacfg_bank_test.sv
`timescale 1ns/1ps
module dmacfg_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        err_event = 1'b0;
  logic        err_flag, master_on;
  logic [7:0]  chan_en, burst_only, alt_sel, hi_prio, req_mask, sw_req;
  logic [31:0] table_base, alt_base;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dmacfg_bank uut (.*);

  // {write addr, write data, read addr, expected read}
  localparam int NV = 25;
  localparam logic [73:0] VEC [NV] = '{
    {5'd8,  32'h0000_00A5, 5'd8,  32'h0000_00A5}, // R2 set
    {5'd8,  32'h0000_0003, 5'd8,  32'h0000_00A7}, // R2 zeros keep
    {5'd9,  32'h0000_0081, 5'd8,  32'h0000_0026}, // R3 clear
    {5'd9,  32'h0000_0000, 5'd8,  32'h0000_0026}, // R3 zero clear
    {5'd10, 32'h0000_00FF, 5'd8,  32'h0000_0026}, // R5 burst vs enable
    {5'd16, 32'h0000_003C, 5'd10, 32'h0000_00FF}, // R5 mask vs burst
    {5'd11, 32'h0000_00F0, 5'd10, 32'h0000_000F}, // R3 burst clear
    {5'd12, 32'h0000_0011, 5'd12, 32'h0000_0011}, // R2 alternate
    {5'd14, 32'h0000_0080, 5'd14, 32'h0000_0080}, // R2 priority
    {5'd15, 32'h0000_00FF, 5'd14, 32'h0000_0000}, // R3 priority
    {5'd13, 32'h0000_0001, 5'd16, 32'h0000_003C}, // R5 alt vs mask
    {5'd13, 32'h0000_0000, 5'd12, 32'h0000_0010}, // R3 alternate
    {5'd8,  32'hFFFF_FF00, 5'd8,  32'h0000_0026}, // R2 upper bits
    {5'd0,  32'h0000_0001, 5'd9,  32'h0000_0000}, // R4 clear addr reads 0
    {5'd0,  32'hFFFF_FFFF, 5'd0,  32'h0000_0001}, // R7 on
    {5'd0,  32'h0000_0000, 5'd0,  32'h0000_0000}, // R7 off
    {5'd2,  32'h2000_0400, 5'd2,  32'h2000_0400}, // R9 legal
    {5'd2,  32'h2000_0404, 5'd2,  32'h2000_0400}, // R9 misaligned
    {5'd2,  32'h1FFF_FC00, 5'd2,  32'h2000_0400}, // R9 too low
    {5'd2,  32'h2000_0000, 5'd3,  32'h2000_0200}, // R10 derived
    {5'd3,  32'h4000_0000, 5'd3,  32'h2000_0200}, // R10 read-only
    {5'd2,  32'hFFFF_FC00, 5'd2,  32'hFFFF_FC00}, // R9 top
    {5'd20, 32'h0000_00FF, 5'd20, 32'h0000_0000}, // R11 reserved read
    {5'd31, 32'h0000_00FF, 5'd8,  32'h0000_0026}, // R11 reserved write
    {5'd4,  32'h0000_00FF, 5'd4,  32'h0000_0000}  // R6 reads zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R4 valid", {31'd0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enable", {24'd0, chan_en | burst_only | alt_sel | hi_prio | req_mask}, 32'd0);
    chk("R1 flags", {29'd0, err_flag, master_on, |sw_req}, 32'd0);
    chk("R1 base", table_base, 32'd0);
    rd(5'd3, r);
    chk("R1 alt", r, 32'h0000_0200);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][73:69], VEC[i][68:37]);
      rd(VEC[i][36:32], r);
      chk($sformatf("vector %0d", i), r, VEC[i][31:0]);
    end

    // R5 final vectors at the pins
    chk("R5 pins", {chan_en, burst_only, alt_sel, req_mask}, 32'h260F_103C);
    chk("R5 prio", {24'd0, hi_prio}, 32'd0);
    chk("R10 pin", alt_base, 32'hFFFF_FE00);

    // R6 pulse lasts exactly one cycle
    wr(5'd4, 32'h0000_005A);
    chk("R6 pulse", {24'd0, sw_req}, 32'h5A);
    @(negedge clk);
    chk("R6 self-clear", {24'd0, sw_req}, 32'd0);

    // R7 pin follows bit 0
    wr(5'd0, 32'h0000_0003);
    chk("R7 pin", {31'd0, master_on}, 32'd1);

    // R8 set, read, clear, collision
    @(negedge clk); err_event = 1'b1;
    @(negedge clk); err_event = 1'b0;
    chk("R8 set", {31'd0, err_flag}, 32'd1);
    rd(5'd1, r);
    chk("R8 read", r, 32'd1);
    wr(5'd1, 32'd0);
    chk("R8 clear", {31'd0, err_flag}, 32'd0);
    @(negedge clk);
    err_event = 1'b1; bus_wr = 1'b1; bus_addr = 5'd1; bus_wdata = 32'd1;
    @(negedge clk);
    err_event = 1'b0; bus_wr = 1'b0;
    chk("R8 collision", {31'd0, err_flag}, 32'd1);
    rd(5'd1, r);
    chk("R8 collision read", r, 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule